// File: doc/BRIEF.md
# Masked Power-Domain Control Register Block

This block holds the software-visible control bits for up to sixteen power domains: one word of power-off requests and one word of bus idle requests. Each control word is updated through a masked write. The upper half of the written data selects the lower-half bits that take a new value. A single domain can therefore be switched without a read-modify-write sequence, and without disturbing the other domains.

The block also presents three read-only words that a power sequencer drives: per-domain power status, idle status and handshake acknowledge. Access is over a simple single-cycle register bus. It has a write strobe, a read strobe, an 8-bit byte offset and 32-bit data. Read data is registered.

Offsets used:
- 0x00: masked power-off control
- 0x04: masked idle-request control
- 0x08: power status
- 0x0C: idle status
- 0x10: acknowledge

Top module: `pwr_ctl_regs`

## Requirements
- R1: After reset, `pwr_off_req`, `idle_req` and `rd_data` are all zero, so every domain comes out of reset powered and not idle.
- R2: A write to offset 0x00 sets bit n of `pwr_off_req` to `wdata[n]` when `wdata[n+16]` is 1. Every bit whose `wdata[n+16]` is 0 keeps its value. A 1 in `pwr_off_req` requests power-off and a 0 requests power-on. The new value appears after the clock edge that samples the write.
- R3: A write to offset 0x04 updates `idle_req` with the same masked rule as R2. A 1 asks the domain's bus interface to go idle and a 0 releases it.
- R4: A read of offset 0x00 or 0x04 returns the matching control word in bits 15:0 and zeros in bits 31:16.
- R5: A read of offset 0x08 returns `dom_off_sts` (1 = domain off, 0 = powered). A read of 0x0C returns `dom_idle_sts` and a read of 0x10 returns `dom_ack_sts`. Each value sits in bits 15:0, with zeros above, as sampled at the read edge.
- R6: A write to a read-only or unmapped offset (anything other than 0x00 and 0x04) leaves `pwr_off_req` and `idle_req` unchanged.
- R7: A read of any unmapped offset returns zero. This includes misaligned offsets such as 0x02, and everything from 0x14 upward.
- R8: `rd_data` is loaded on the clock edge that samples `rd_en`. It holds its value until the next read. A read and a write to the same control offset in the same cycle return the value from before the write.
- R9: A write whose mask half (`wdata[31:16]`) is all zero changes no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data: bits 31:16 are the mask, bits 15:0 are the values |
| rd_data | output | 32 | Registered read data |
| pwr_off_req | output | 16 | Per-domain power-off request (1 = off) |
| idle_req | output | 16 | Per-domain bus idle request (1 = go idle) |
| dom_off_sts | input | 16 | Per-domain power status from the sequencer (1 = off) |
| dom_idle_sts | input | 16 | Per-domain idle status from the sequencer |
| dom_ack_sts | input | 16 | Per-domain idle handshake acknowledge from the sequencer |

## Verification
A wrong bit in either control word is visible on `pwr_off_req` or `idle_req` at the first falling edge after the write that caused it. It also reappears in `rd_data` one cycle after any read of that word. A wrong decode or read-select choice shows as wrong or non-zero `rd_data` in the cycle right after the read strobe. The random mix of masks, offsets and status values means that a stuck, swapped or unmasked bit shows within a few accesses. It then stays visible, because the bench model and the outputs are compared after every operation.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  localparam logic [7:0] OFS_PWR_CTL  = 8'h00;
  localparam logic [7:0] OFS_IDLE_CTL = 8'h04;
  localparam logic [7:0] OFS_OFF_STS  = 8'h08;
  localparam logic [7:0] OFS_IDLE_STS = 8'h0C;
  localparam logic [7:0] OFS_ACK_STS  = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PWR,
    SEL_IDLE,
    SEL_OFF,
    SEL_IDST,
    SEL_ACK
  } reg_sel_e;

endpackage

// File: rtl/pwr_ctl_decode.sv
module pwr_ctl_decode
  import pwr_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_PWR_CTL))       sel = SEL_PWR;
    else if (addr == ADDR_W'(OFS_IDLE_CTL)) sel = SEL_IDLE;
    else if (addr == ADDR_W'(OFS_OFF_STS))  sel = SEL_OFF;
    else if (addr == ADDR_W'(OFS_IDLE_STS)) sel = SEL_IDST;
    else if (addr == ADDR_W'(OFS_ACK_STS))  sel = SEL_ACK;
  end

endmodule

// File: rtl/pwr_ctl_mreg.sv
// Control word updated by a write whose upper half is a per-bit enable.
module pwr_ctl_mreg #(
  parameter int NUM_DOM = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_DOM-1:0] q
);

  localparam int HALF = DATA_W / 2;

  logic [NUM_DOM-1:0] q_nxt;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_bit
    always_comb begin
      q_nxt[i] = wdata[i+HALF] ? wdata[i] : q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= q_nxt;
  end

endmodule

// File: rtl/pwr_ctl_rdmux.sv
module pwr_ctl_rdmux
  import pwr_ctl_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_DOM-1:0] pwr_q,
  input  logic [NUM_DOM-1:0] idle_q,
  input  logic [NUM_DOM-1:0] off_sts,
  input  logic [NUM_DOM-1:0] idle_sts,
  input  logic [NUM_DOM-1:0] ack_sts,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int PAD = DATA_W - NUM_DOM;

  logic [NUM_DOM-1:0] pick;
  logic [DATA_W-1:0]  rd_nxt;

  always_comb begin
    unique case (sel)
      SEL_PWR:  pick = pwr_q;
      SEL_IDLE: pick = idle_q;
      SEL_OFF:  pick = off_sts;
      SEL_IDST: pick = idle_sts;
      SEL_ACK:  pick = ack_sts;
      default:  pick = '0;
    endcase
    rd_nxt = {{PAD{1'b0}}, pick};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

endmodule

// File: rtl/pwr_ctl_regs.sv
// NUM_DOM must not exceed DATA_W/2, since each value bit needs a mask bit.
module pwr_ctl_regs
  import pwr_ctl_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_DOM-1:0] pwr_off_req,
  output logic [NUM_DOM-1:0] idle_req,
  input  logic [NUM_DOM-1:0] dom_off_sts,
  input  logic [NUM_DOM-1:0] dom_idle_sts,
  input  logic [NUM_DOM-1:0] dom_ack_sts
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  reg_sel_e sel;
  logic     wr_pwr;
  logic     wr_idle;

  pwr_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  assign wr_pwr  = wr_en && (sel == SEL_PWR);
  assign wr_idle = wr_en && (sel == SEL_IDLE);

  pwr_ctl_mreg #(.NUM_DOM(NUM_DOM), .DATA_W(DATA_W)) u_pwr (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_hit (wr_pwr),
    .wdata  (wdata),
    .q      (pwr_off_req)
  );

  pwr_ctl_mreg #(.NUM_DOM(NUM_DOM), .DATA_W(DATA_W)) u_idle (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_hit (wr_idle),
    .wdata  (wdata),
    .q      (idle_req)
  );

  pwr_ctl_rdmux #(.NUM_DOM(NUM_DOM), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_q),
    .rd_en    (rd_en),
    .sel      (sel),
    .pwr_q    (pwr_off_req),
    .idle_q   (idle_req),
    .off_sts  (dom_off_sts),
    .idle_sts (dom_idle_sts),
    .ack_sts  (dom_ack_sts),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/pwr_ctl_regs_chk.sv
module pwr_ctl_regs_chk
  import pwr_ctl_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rd_data,
  input logic [NUM_DOM-1:0] pwr_off_req,
  input logic [NUM_DOM-1:0] idle_req
);

  localparam int HALF = DATA_W / 2;

  logic [NUM_DOM-1:0] w_val;
  logic [NUM_DOM-1:0] w_msk;
  logic               hit_pwr;
  logic               hit_idle;
  logic               mapped;

  assign w_val    = wdata[NUM_DOM-1:0];
  assign w_msk    = wdata[HALF+NUM_DOM-1:HALF];
  assign hit_pwr  = (addr == ADDR_W'(OFS_PWR_CTL));
  assign hit_idle = (addr == ADDR_W'(OFS_IDLE_CTL));
  assign mapped   = hit_pwr || hit_idle ||
                    (addr == ADDR_W'(OFS_OFF_STS)) ||
                    (addr == ADDR_W'(OFS_IDLE_STS)) ||
                    (addr == ADDR_W'(OFS_ACK_STS));

  // R2
  a_r2_pwr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_pwr) |=>
      pwr_off_req == (($past(pwr_off_req) & ~$past(w_msk)) | ($past(w_val) & $past(w_msk))));

  // R3
  a_r3_idle_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_idle) |=>
      idle_req == (($past(idle_req) & ~$past(w_msk)) | ($past(w_val) & $past(w_msk))));

  // R6
  a_r6_pwr_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_pwr) |=> $stable(pwr_off_req));

  // R6
  a_r6_idle_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_idle) |=> $stable(idle_req));

  // R4
  a_r4_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (hit_pwr || hit_idle)) |=> (rd_data[DATA_W-1:HALF] == '0));

  // R7
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rd_data == '0));

  // R8
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R9
  a_r9_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (w_msk == '0)) |=> ($stable(pwr_off_req) && $stable(idle_req)));

endmodule

bind pwr_ctl_regs pwr_ctl_regs_chk #(
  .NUM_DOM (NUM_DOM),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .rd_data     (rd_data),
  .pwr_off_req (pwr_off_req),
  .idle_req    (idle_req)
);

// File: tb/pwr_ctl_regs_test.sv
`timescale 1ns/1ps
module pwr_ctl_regs_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rd_data;
  logic [15:0] pwr_off_req;
  logic [15:0] idle_req;
  logic [15:0] dom_off_sts;
  logic [15:0] dom_idle_sts;
  logic [15:0] dom_ack_sts;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [15:0] m_pwr;
  logic [15:0] m_idle;

  always #4 clk = ~clk;

  pwr_ctl_regs uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rd_data      (rd_data),
    .pwr_off_req  (pwr_off_req),
    .idle_req     (idle_req),
    .dom_off_sts  (dom_off_sts),
    .dom_idle_sts (dom_idle_sts),
    .dom_ack_sts  (dom_ack_sts)
  );

  function automatic logic [15:0] mupd(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] rd_exp(logic [7:0] a);
    case (a)
      8'h00:   return {16'h0, m_pwr};
      8'h04:   return {16'h0, m_idle};
      8'h08:   return {16'h0, dom_off_sts};
      8'h0C:   return {16'h0, dom_idle_sts};
      8'h10:   return {16'h0, dom_ack_sts};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a == 8'h00) m_pwr  = mupd(m_pwr, d);
    if (a == 8'h04) m_idle = mupd(m_idle, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_ctl(string tag);
    chk({tag, " pwr_off_req"}, {16'h0, pwr_off_req}, {16'h0, m_pwr});
    chk({tag, " idle_req"}, {16'h0, idle_req}, {16'h0, m_idle});
  endtask

  task automatic do_rd(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e = rd_exp(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, e);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] tbl [0:7];
    logic [31:0] e;
    void'($urandom(32'd1234));
    tbl[0] = 8'h00; tbl[1] = 8'h04; tbl[2] = 8'h08; tbl[3] = 8'h0C;
    tbl[4] = 8'h10; tbl[5] = 8'h14; tbl[6] = 8'h02; tbl[7] = 8'hFC;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    dom_off_sts = 16'hA5C3; dom_idle_sts = 16'h0F0F; dom_ack_sts = 16'h3C3C;
    m_pwr = '0; m_idle = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_ctl("R1 reset");
    chk("R1 rd_data reset", rd_data, 32'h0);

    // R2 single bit set, others untouched
    do_wr(8'h00, 32'h0008_FFFF);
    chk_ctl("R2 single bit");
    do_wr(8'h00, 32'hFFFF_00F0);
    chk_ctl("R2 full mask");
    do_wr(8'h00, 32'h0011_0000);
    chk_ctl("R2 clear two");
    // R3
    do_wr(8'h04, 32'h8001_FFFF);
    chk_ctl("R3 idle edges");
    // R9 zero mask
    do_wr(8'h00, 32'h0000_FFFF);
    chk_ctl("R9 zero mask pwr");
    do_wr(8'h04, 32'h0000_0000);
    chk_ctl("R9 zero mask idle");
    // R6 writes to read-only / unmapped offsets
    do_wr(8'h08, 32'hFFFF_FFFF);
    do_wr(8'h0C, 32'hFFFF_0000);
    do_wr(8'h10, 32'hFFFF_FFFF);
    do_wr(8'h02, 32'hFFFF_FFFF);
    chk_ctl("R6 ro writes");
    // R4 upper half zero on readback
    do_rd(8'h00, "R4 read pwr ctl");
    do_rd(8'h04, "R4 read idle ctl");
    // R5 status words
    do_rd(8'h08, "R5 off status");
    do_rd(8'h0C, "R5 idle status");
    do_rd(8'h10, "R5 ack status");
    // R7 unmapped
    do_rd(8'h14, "R7 unmapped 0x14");
    do_rd(8'h01, "R7 misaligned 0x01");
    // R8 hold after read
    e = rd_data;
    repeat (3) @(negedge clk);
    chk("R8 hold", rd_data, e);
    // R8 simultaneous read and write returns old value
    @(negedge clk);
    e = {16'h0, m_pwr};
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h00; wdata = 32'hFFFF_1234;
    m_pwr = mupd(m_pwr, 32'hFFFF_1234);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R8 read with write", rd_data, e);
    chk_ctl("R2 after combined");

    // random mix (R2 R3 R5 R6 R7 R9)
    for (int k = 0; k < 600; k++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = tbl[$urandom % 8];
      d = $urandom;
      if (($urandom % 4) == 0) d[31:16] = 16'h0;
      dom_off_sts  = 16'($urandom);
      dom_idle_sts = 16'($urandom);
      dom_ack_sts  = 16'($urandom);
      if ($urandom % 2) begin
        do_wr(a, d);
        chk_ctl("R2/R3/R6/R9 random write");
      end else begin
        do_rd(a, "R4/R5/R7 random read");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule